// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Stuff-Bit Removal

This block sits directly on the oversampled CAN receive line, which is synchronous to the block clock. While the bus is idle it waits for the first dominant (logic 0) sample and treats the clock in which that sample is seen as the frame's time reference. Every bit of the frame is then sampled at a fixed point inside its bit period. That point is computed from this single reference and is never re-aligned to later edges. The bit period in clocks and the sample point as a percentage of the period are parameters.

Each sampled bit first passes a destuffer. After five equal raw bits, the next bit of the opposite level is a stuff bit. It is counted but not delivered, and a one-clock flag reports it. Every other bit is presented on a valid/ready output together with two indices: its position among the frame bits, where the start-of-frame bit is 0, and its position among all sampled bits. A downstream frame parser sends a one-clock end-of-frame pulse. That pulse returns the block to idle and clears its counters and its run history.

Back-pressure rules: `out_valid` stays high, and the payload stays stable, until a clock in which `out_ready` is high. The line cannot be stalled. If the next frame bit is sampled while the previous one has not been accepted, the new bit replaces the old one, so a consumer must accept each bit within one bit period.

Top module: `canrx_bit_sampler`

## Requirements
- R1: In idle, recessive samples (rx = 1) are ignored and produce no output. The first clock with rx = 0 is the frame's reference clock t = 0.
- R2: Raw bit n is taken from rx in the clock t = n·CLK_PER_BIT + OFS after the reference clock. The matching out_valid (or stuff_flag) appears one clock later. Successive samples are exactly CLK_PER_BIT clocks apart.
- R3: OFS = floor(CLK_PER_BIT·SAMPLE_PCT/100), limited to the range 1 to CLK_PER_BIT−1. With the defaults (125 clocks, 70 %) OFS is 87.
- R4: A sampled bit is a stuff bit when the five raw bits before it (stuff bits included) are all equal and it differs from them. A stuff bit is never presented on out_valid.
- R5: out_idx counts only the frame bits delivered, so the SOF bit has out_idx = 0. out_raw_idx counts every sampled bit, stuff bits included. Both start at 0 at each SOF.
- R6: stuff_flag is high for exactly one clock for each stuff bit dropped, in the clock after that bit's sample.
- R7: An end-of-frame pulse returns the block to idle, clears both counters, and drops any pending output in the next clock. No sample is taken after it until a new SOF.
- R8: The run history is cleared at SOF, so the SOF bit is the first bit of a run. No run carries over from an earlier frame.
- R9: While out_valid is high and out_ready is low, out_valid, out_bit and out_idx hold until the next frame bit is sampled, which replaces them. A clock with out_ready high and no new bit clears out_valid.
- R10: After reset, out_valid and stuff_flag are 0 and the block is idle.
- R11: A run longer than five equal bits, which is not a legal frame, keeps the run count at its limit. The next opposite bit is still removed as a stuff bit. For example, 000000 followed by 1 drops the 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx | input | 1 | CAN receive line, synchronous to clk (0 = dominant) |
| frame_end | input | 1 | One-clock end-of-frame pulse from the parser |
| out_ready | input | 1 | Consumer accepts the presented bit |
| out_valid | output | 1 | A destuffed frame bit is presented |
| out_bit | output | 1 | Value of the presented bit |
| out_idx | output | IDX_W | Frame-bit index, with SOF = 0 and stuff bits excluded |
| out_raw_idx | output | IDX_W | Raw-bit index, with stuff bits included |
| stuff_flag | output | 1 | One-clock pulse for each stuff bit removed |

## Verification
The bench builds the block with a 10-clock bit period and a 70 % sample point, so OFS is 7. A bit therefore lands on out_valid 8 clocks after the reference and every 10 clocks after that, and whole frames of a dozen bits fit in a few hundred cycles. With this short period, the exact capture clock of each bit can be compared with the computed one. It also lets one run cover stuff bits that follow another stuff bit, over-long runs, history clearing between frames, an abort in the middle of a frame, and the replacement of an unaccepted bit.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } canrx_state_e;

  // Sample offset inside a bit, kept strictly inside the period.
  function automatic int calc_sample_ofs(input int period, input int pct);
    int ofs;
    ofs = (period * pct) / 100;
    if (ofs < 1) ofs = 1;
    if (ofs > period - 1) ofs = period - 1;
    return ofs;
  endfunction

endpackage

// File: rtl/canrx_bit_timer.sv
module canrx_bit_timer
  import canrx_pkg::*;
#(
  parameter int CLK_PER_BIT = 125,
  parameter int SAMPLE_OFS  = 87
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  input  logic frame_end,
  output logic start_tick,
  output logic sample_tick
);

  localparam int PH_W = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_OFS);

  canrx_state_e    state;
  logic [PH_W-1:0] phase;

  always_comb begin
    start_tick  = (state == ST_IDLE) && !rx && !frame_end;
    sample_tick = (state == ST_RUN) && (phase == PH_SMP) && !frame_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (start_tick) begin
      state <= ST_RUN;
      phase <= PH_W'(1);
    end else if (state == ST_RUN) begin
      phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
    end
  end

  // R1
  idle_on_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rx && !frame_end) |=> (state == ST_IDLE));

  // R2
  no_sample_at_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_tick |=> !sample_tick);

  // R2
  sample_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  // R7
  end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == ST_IDLE && !sample_tick));

endmodule

// File: rtl/canrx_destuff.sv
module canrx_destuff #(
  parameter int IDX_W     = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic             start_tick,
  input  logic             sample_tick,
  input  logic             frame_end,
  output logic             new_bit,
  output logic             stuff_tick,
  output logic [IDX_W-1:0] frame_idx,
  output logic [IDX_W-1:0] raw_idx
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

  logic [RUN_W-1:0] run_len;
  logic             run_val;
  logic             is_stuff;

  always_comb begin
    is_stuff   = (run_len == RUN_MAX) && (rx != run_val);
    new_bit    = sample_tick && !is_stuff;
    stuff_tick = sample_tick && is_stuff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end || start_tick) begin
      run_len   <= '0;
      run_val   <= 1'b0;
      frame_idx <= '0;
      raw_idx   <= '0;
    end else if (sample_tick) begin
      raw_idx <= raw_idx + IDX_W'(1);
      if (is_stuff) begin
        run_val <= rx;
        run_len <= RUN_W'(1);
      end else begin
        frame_idx <= frame_idx + IDX_W'(1);
        if (run_len == '0 || rx != run_val) begin
          run_val <= rx;
          run_len <= RUN_W'(1);
        end else if (run_len != RUN_MAX) begin
          run_len <= run_len + RUN_W'(1);
        end
      end
    end
  end

  // R4
  stuff_restarts_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_tick && !frame_end) |=> (run_len == RUN_W'(1)));

  // R8
  sof_clears_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_tick |=> (run_len == '0 && frame_idx == '0 && raw_idx == '0));

  // R11
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_MAX);

endmodule

// File: rtl/canrx_out_stage.sv
module canrx_out_stage #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             new_bit,
  input  logic             bit_in,
  input  logic [IDX_W-1:0] frame_idx,
  input  logic [IDX_W-1:0] raw_idx,
  input  logic             stuff_tick,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic [IDX_W-1:0] out_idx,
  output logic [IDX_W-1:0] out_raw_idx,
  output logic             stuff_flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bit     <= 1'b1;
      out_idx     <= '0;
      out_raw_idx <= '0;
      stuff_flag  <= 1'b0;
    end else begin
      stuff_flag <= stuff_tick && !frame_end;
      if (frame_end) begin
        out_valid <= 1'b0;
      end else if (new_bit) begin
        out_valid   <= 1'b1;
        out_bit     <= bit_in;
        out_idx     <= frame_idx;
        out_raw_idx <= raw_idx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !new_bit && !frame_end)
      |=> (out_valid && $stable(out_bit) && $stable(out_idx)));

  // R6
  stuff_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_flag |=> !stuff_flag);

  // R5
  stuff_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_flag |-> $stable(out_idx));

  // R7
  end_drops_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !out_valid);

endmodule

// File: rtl/canrx_bit_sampler.sv
module canrx_bit_sampler #(
  parameter int CLK_PER_BIT = 125,
  parameter int SAMPLE_PCT  = 70,
  parameter int IDX_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic             frame_end,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic [IDX_W-1:0] out_idx,
  output logic [IDX_W-1:0] out_raw_idx,
  output logic             stuff_flag
);

  // R3: sample offset derived from period and percentage
  localparam int SAMPLE_OFS = canrx_pkg::calc_sample_ofs(CLK_PER_BIT, SAMPLE_PCT);
  localparam int STUFF_RUN  = 5;

  logic             start_tick;
  logic             sample_tick;
  logic             new_bit;
  logic             stuff_tick;
  logic [IDX_W-1:0] frame_idx;
  logic [IDX_W-1:0] raw_idx;

  canrx_bit_timer #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .SAMPLE_OFS  (SAMPLE_OFS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx          (rx),
    .frame_end   (frame_end),
    .start_tick  (start_tick),
    .sample_tick (sample_tick)
  );

  canrx_destuff #(
    .IDX_W     (IDX_W),
    .STUFF_RUN (STUFF_RUN)
  ) u_destuff (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx          (rx),
    .start_tick  (start_tick),
    .sample_tick (sample_tick),
    .frame_end   (frame_end),
    .new_bit     (new_bit),
    .stuff_tick  (stuff_tick),
    .frame_idx   (frame_idx),
    .raw_idx     (raw_idx)
  );

  canrx_out_stage #(
    .IDX_W (IDX_W)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_end   (frame_end),
    .new_bit     (new_bit),
    .bit_in      (rx),
    .frame_idx   (frame_idx),
    .raw_idx     (raw_idx),
    .stuff_tick  (stuff_tick),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .out_idx     (out_idx),
    .out_raw_idx (out_raw_idx),
    .stuff_flag  (stuff_flag)
  );

endmodule

// File: tb/canrx_bit_sampler_test.sv
`timescale 1ns/1ps
module canrx_bit_sampler_test;

  localparam int P     = 10;
  localparam int PCT   = 70;
  localparam int IDX_W = 8;
  localparam int FIRST = 8;   // OFS (7) + 1 output register

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic frame_end = 1'b0;
  logic out_ready = 1'b1;
  logic out_valid, out_bit, stuff_flag;
  logic [IDX_W-1:0] out_idx, out_raw_idx;

  int errors = 0;
  int checks = 0;
  int ncyc = 0;

  int cap_n = 0;
  int stuff_n = 0;
  logic cap_bit [64];
  int cap_idx [64];
  int cap_raw [64];
  int cap_t [64];

  always #4 clk = ~clk;

  canrx_bit_sampler #(.CLK_PER_BIT(P), .SAMPLE_PCT(PCT), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .frame_end(frame_end),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_idx(out_idx), .out_raw_idx(out_raw_idx), .stuff_flag(stuff_flag)
  );

  always @(posedge clk) ncyc++;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap_bit[cap_n] = out_bit;
      cap_idx[cap_n] = int'(out_idx);
      cap_raw[cap_n] = int'(out_raw_idx);
      cap_t[cap_n]   = ncyc;
      cap_n++;
    end
    if (rst_n && stuff_flag) stuff_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_caps();
    cap_n = 0;
    stuff_n = 0;
  endtask

  // Sends raw bits seq[0..n-1], each held P clocks, then pulses frame_end.
  task automatic send_frame(input logic [63:0] seq, input int n, output int c0);
    @(negedge clk);
    c0 = ncyc;
    for (int i = 0; i < n; i++) begin
      rx = seq[i];
      repeat (P) @(negedge clk);
    end
    rx = 1'b1;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid after reset", int'(out_valid), 0);
    chk(stuff_flag == 1'b0, "R10 stuff after reset", int'(stuff_flag), 0);
  endtask

  task automatic t_idle();
    clear_caps();
    rx = 1'b1;
    repeat (50) @(negedge clk);
    chk(cap_n == 0, "R1 no output on recessive idle", cap_n, 0);
    chk(stuff_n == 0, "R1 no stuff on idle", stuff_n, 0);
  endtask

  task automatic t_destuff_timing();
    int c0;
    logic [63:0] seq;
    int exp_raw [11];
    logic [10:0] exp_val;
    clear_caps();
    // raw 0 0 0 0 0 1* 1 1 1 1 0* 1 0 (* = stuff)
    seq = 64'hBE0;
    exp_val = 11'h3E0;
    for (int k = 0; k < 11; k++)
      exp_raw[k] = (k < 5) ? k : (k < 9) ? k + 1 : k + 2;
    send_frame(seq, 13, c0);
    chk(cap_n == 11, "R4 frame bit count", cap_n, 11);
    chk(stuff_n == 2, "R6 stuff pulses one clock each", stuff_n, 2);
    chk(cap_t[0] - c0 == FIRST, "R2 R3 first bit capture clock", cap_t[0] - c0, FIRST);
    chk(cap_t[1] - cap_t[0] == P, "R2 bit spacing", cap_t[1] - cap_t[0], P);
    for (int k = 0; k < 11; k++) begin
      chk(cap_bit[k] == exp_val[k], "R4 bit value", int'(cap_bit[k]), int'(exp_val[k]));
      chk(cap_idx[k] == k, "R5 frame index", cap_idx[k], k);
      chk(cap_raw[k] == exp_raw[k], "R5 raw index", cap_raw[k], exp_raw[k]);
      chk(cap_t[k] - c0 == FIRST + P * exp_raw[k], "R2 capture clock",
          cap_t[k] - c0, FIRST + P * exp_raw[k]);
    end
  endtask

  task automatic t_long_run();
    int c0;
    clear_caps();
    // raw 0 0 0 0 0 0 1* 0
    send_frame(64'h40, 8, c0);
    chk(cap_n == 7, "R11 frame bits after long run", cap_n, 7);
    chk(stuff_n == 1, "R11 stuff after long run", stuff_n, 1);
    chk(cap_raw[6] == 7, "R11 raw index after stuff", cap_raw[6], 7);
    chk(cap_bit[6] == 1'b0, "R11 bit after stuff", int'(cap_bit[6]), 0);
  endtask

  task automatic t_near_miss();
    int c0;
    clear_caps();
    // raw 0 0 0 0 1 1 1 1 0 : runs of four, no stuffing
    send_frame(64'h0F0, 9, c0);
    chk(cap_n == 9, "R4 runs of four not stuffed", cap_n, 9);
    chk(stuff_n == 0, "R4 no stuff on runs of four", stuff_n, 0);
  endtask

  task automatic t_history_reset();
    int c0;
    clear_caps();
    send_frame(64'h0, 3, c0);        // ends with a run of three zeros
    clear_caps();
    send_frame(64'h10, 5, c0);       // SOF + three zeros, then 1
    chk(cap_n == 5, "R8 history cleared at SOF", cap_n, 5);
    chk(stuff_n == 0, "R8 no carried-over stuff", stuff_n, 0);
    chk(cap_bit[4] == 1'b1, "R8 last bit delivered", int'(cap_bit[4]), 1);
  endtask

  task automatic t_abort();
    int c0;
    clear_caps();
    send_frame(64'h2, 3, c0);        // 0 1 0, then abort
    chk(cap_n == 3, "R7 bits before abort", cap_n, 3);
    repeat (30) @(negedge clk);
    chk(cap_n == 3, "R7 no samples after abort", cap_n, 3);
    clear_caps();
    send_frame(64'h2, 2, c0);
    chk(cap_n == 2 && cap_idx[0] == 0 && cap_raw[0] == 0,
        "R7 indices restart after abort", cap_idx[0], 0);
    chk(cap_t[0] - c0 == FIRST, "R7 new reference after abort", cap_t[0] - c0, FIRST);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    @(negedge clk);
    rx = 1'b0;                        // SOF at N0
    repeat (8) @(negedge clk);        // N0+8
    chk(out_valid == 1'b1 && out_idx == 0, "R9 first bit presented", int'(out_valid), 1);
    repeat (2) @(negedge clk);        // N0+10
    rx = 1'b1;
    repeat (2) @(negedge clk);        // N0+12
    chk(out_valid == 1'b1 && out_idx == 0 && out_bit == 1'b0,
        "R9 held while not ready", int'(out_idx), 0);
    repeat (6) @(negedge clk);        // N0+18
    chk(out_valid == 1'b1 && out_idx == 1 && out_bit == 1'b1,
        "R9 replaced by next bit", int'(out_idx), 1);
    out_ready = 1'b1;
    @(negedge clk);                   // N0+19
    chk(out_valid == 1'b0, "R9 cleared after accept", int'(out_valid), 0);
    out_ready = 1'b0;
    @(negedge clk);                   // N0+20
    rx = 1'b0;
    repeat (8) @(negedge clk);        // N0+28
    chk(out_valid == 1'b1 && out_idx == 2, "R9 pending third bit", int'(out_idx), 2);
    frame_end = 1'b1;
    rx = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(out_valid == 1'b0, "R7 pending bit dropped", int'(out_valid), 0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_destuff_timing();
    t_long_run();
    t_near_miss();
    t_history_reset();
    t_abort();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule